// File: doc/BRIEF.md
# Receive FIFO with Hysteretic Auto-RTS

This block is the receive-side byte store of a single asynchronous serial channel. A deserializer upstream hands it one byte per strobe. A CPU downstream pulls bytes out in arrival order and watches the fill count, the data-ready flag and two interrupts. The trigger interrupt reports that a selected fill level has been reached. The timeout interrupt reports that a few bytes are waiting below that level and that the line has gone quiet.

When automatic flow control is on, the block drives an active-low request-to-send output. It releases the request, driving it high, as soon as the fill count reaches the selected trigger level. It asserts the request again, driving it low, only after the CPU has drained the FIFO down to a lower threshold that belongs to that level. The gap between the two points stops the line from chattering around one count. While the request is released, bytes that the far end still sends are accepted until all 32 entries are used. A byte that arrives into a full FIFO is dropped and recorded as an overrun.

Top module: `rx_fifo_rts`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, the block shows: `fill_count` 0, `data_ready` 0, `trig_irq` 0, `timeout_irq` 0, `overrun` 0 and `rts_n` 1.
- R2: Bytes leave in arrival order. `rd_data` always shows the oldest stored byte. Each accepted `wr_en` adds one to `fill_count` and each `rd_en` on a non-empty FIFO subtracts one, both on the same clock edge. `data_ready` is 1 exactly when `fill_count` is nonzero. A read strobe on an empty FIFO changes nothing.
- R3: `trig_sel` encodes the trigger level: 00 gives 8, 01 gives 16, 10 gives 24 and 11 gives 28. `trig_irq` is 1 exactly while `fill_count` is at or above the selected level.
- R4: With `auto_rts_en` high, `rts_n` goes to 1 on the same edge on which `fill_count` reaches the selected level.
- R5: With `auto_rts_en` high, `rts_n` goes to 0 on the edge on which `fill_count` falls to or below the release threshold. The thresholds are 0, 7, 15 and 23 for levels 8, 16, 24 and 28. Between the release threshold and the trigger level, `rts_n` keeps its previous value.
- R6: With `auto_rts_en` low, `rts_n` is 1 from the next edge on.
- R7: Writes are still accepted while `rts_n` is 1, until `fill_count` reaches 32.
- R8: A write to a full FIFO without a read in the same cycle is discarded, leaves the stored bytes unchanged and sets `overrun`. `overrun` stays set until the next `rd_en`, which clears it. A write together with a read on a full FIFO stores the byte.
- R9: `timeout_irq` becomes 1 after 4 `char_tick` pulses with no `wr_en` and no `rd_en`, while `fill_count` is between 1 and the trigger level minus one. It drops on the edge after any `wr_en` or `rd_en`. It is never 1 while the FIFO is empty or at or above the trigger level.
- R10: With `fifo_en` low, the FIFO is emptied on the next edge and incoming bytes are discarded without setting `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Received-byte strobe |
| wr_data | input | 8 | Received byte |
| rd_en | input | 1 | CPU read strobe, pops the oldest byte |
| fifo_en | input | 1 | FIFO enable; low flushes the FIFO and blocks writes |
| trig_sel | input | 2 | Trigger level select (00=8, 01=16, 10=24, 11=28) |
| auto_rts_en | input | 1 | Enables automatic RTS control |
| char_tick | input | 1 | One pulse per character time |
| rd_data | output | 8 | Oldest stored byte |
| fill_count | output | 6 | Number of stored bytes, 0 to 32 |
| data_ready | output | 1 | FIFO not empty |
| trig_irq | output | 1 | Fill count at or above the trigger level |
| timeout_irq | output | 1 | Receive timeout |
| overrun | output | 1 | Sticky: a byte was dropped because the FIFO was full |
| rts_n | output | 1 | Request to send, active low |

## Verification
Two pairs of events can fall in the same cycle.

- A read and a write on a full FIFO: the bench provokes this directly. The expected result is that `fill_count` stays at 32, the new byte appears at the tail and `overrun` is cleared rather than set.
- A character tick and a read or write: the random phases produce this naturally, since they drive `char_tick`, `wr_en` and `rd_en` independently. The bench model expects the strobe to restart the timeout window.

Each cycle the bench compares the count, the head byte, `rts_n` and both interrupts against a queue model. That model moves `rts_n` only at the trigger level and at the release threshold.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;

    typedef enum logic [1:0] {
        TRIG_8  = 2'b00,
        TRIG_16 = 2'b01,
        TRIG_24 = 2'b10,
        TRIG_28 = 2'b11
    } trig_sel_e;

    typedef struct packed {
        logic push;
        logic pop;
        logic flush;
    } fifo_op_t;

    // Fill level that raises the interrupt and releases RTS
    function automatic int unsigned trig_level(trig_sel_e s);
        case (s)
            TRIG_8:  return 8;
            TRIG_16: return 16;
            TRIG_24: return 24;
            default: return 28;
        endcase
    endfunction

    // Fill level at or below which RTS is asserted again
    function automatic int unsigned release_level(trig_sel_e s);
        case (s)
            TRIG_8:  return 0;
            TRIG_16: return 7;
            TRIG_24: return 15;
            default: return 23;
        endcase
    endfunction

endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store
    import rx_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  fifo_op_t         op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic [CW-1:0]    count_nxt
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        if (op.flush) count_nxt = '0;
        else          count_nxt = count + CW'(op.push) - CW'(op.pop);
    end

    always_ff @(posedge clk) begin
        if (rst || op.flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (op.push) wr_ptr <= bump(wr_ptr);
            if (op.pop)  rd_ptr <= bump(rd_ptr);
            count <= count_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (op.push && !op.flush) mem[wr_ptr] <= din;
    end

    assign dout = mem[rd_ptr];

endmodule

// File: rtl/rx_rts_ctl.sv
module rx_rts_ctl #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          auto_en,
    input  logic [CW-1:0] count_nxt,
    input  logic [CW-1:0] hi_lvl,
    input  logic [CW-1:0] lo_lvl,
    output logic          rts_n
);

    always_ff @(posedge clk) begin
        if (rst || !auto_en)          rts_n <= 1'b1;
        else if (count_nxt >= hi_lvl) rts_n <= 1'b1;
        else if (count_nxt <= lo_lvl) rts_n <= 1'b0;
    end

endmodule

// File: rtl/rx_timeout.sv
module rx_timeout #(
    parameter int TO_CHARS = 4,
    localparam int TW = $clog2(TO_CHARS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic activity,
    input  logic in_window,
    input  logic tick,
    output logic irq
);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || activity || !in_window)       cnt <= '0;
        else if (tick && cnt != TW'(TO_CHARS))   cnt <= cnt + 1'b1;
    end

    assign irq = in_window && (cnt == TW'(TO_CHARS));

endmodule

// File: rtl/rx_fifo_rts.sv
module rx_fifo_rts
    import rx_fifo_pkg::*;
#(
    parameter int DEPTH    = 32,
    parameter int WIDTH    = 8,
    parameter int TO_CHARS = 4,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             fifo_en,
    input  logic [1:0]       trig_sel,
    input  logic             auto_rts_en,
    input  logic             char_tick,
    output logic [WIDTH-1:0] rd_data,
    output logic [CW-1:0]    fill_count,
    output logic             data_ready,
    output logic             trig_irq,
    output logic             timeout_irq,
    output logic             overrun,
    output logic             rts_n
);

    fifo_op_t      op;
    logic [CW-1:0] count_nxt;
    logic [CW-1:0] hi_lvl;
    logic [CW-1:0] lo_lvl;
    logic          full;
    logic          empty;
    logic          ovr_set;

    assign full  = (fill_count == CW'(DEPTH));
    assign empty = (fill_count == '0);

    assign hi_lvl = CW'(trig_level(trig_sel_e'(trig_sel)));
    assign lo_lvl = CW'(release_level(trig_sel_e'(trig_sel)));

    always_comb begin
        op.flush = !fifo_en;
        op.pop   = fifo_en && rd_en && !empty;
        op.push  = fifo_en && wr_en && (!full || op.pop);
    end

    assign ovr_set = fifo_en && wr_en && full && !op.pop;

    always_ff @(posedge clk) begin
        if (rst)          overrun <= 1'b0;
        else if (ovr_set) overrun <= 1'b1;
        else if (rd_en)   overrun <= 1'b0;
    end

    rx_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .din       (wr_data),
        .dout      (rd_data),
        .count     (fill_count),
        .count_nxt (count_nxt)
    );

    rx_rts_ctl #(.CW(CW)) u_rts (
        .clk       (clk),
        .rst       (rst),
        .auto_en   (auto_rts_en),
        .count_nxt (count_nxt),
        .hi_lvl    (hi_lvl),
        .lo_lvl    (lo_lvl),
        .rts_n     (rts_n)
    );

    assign data_ready = !empty;
    assign trig_irq   = (fill_count >= hi_lvl);

    rx_timeout #(.TO_CHARS(TO_CHARS)) u_to (
        .clk       (clk),
        .rst       (rst),
        .activity  (wr_en || rd_en),
        .in_window (!empty && !trig_irq),
        .tick      (char_tick),
        .irq       (timeout_irq)
    );

endmodule

// File: rtl/rx_fifo_rts_chk.sv
module rx_fifo_rts_chk
    import rx_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CW    = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic          fifo_en,
    input logic [1:0]    trig_sel,
    input logic          auto_rts_en,
    input logic [CW-1:0] fill_count,
    input logic          timeout_irq,
    input logic          overrun,
    input logic          rts_n
);

    logic [CW-1:0] lvl;
    logic [CW-1:0] rel;
    assign lvl = CW'(trig_level(trig_sel_e'(trig_sel)));
    assign rel = CW'(release_level(trig_sel_e'(trig_sel)));

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill_count <= CW'(DEPTH));

    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && wr_en && !rd_en && fill_count == CW'(DEPTH))
        |=> (overrun && fill_count == CW'(DEPTH)));

    // R4
    rts_release_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(auto_rts_en) && $past(trig_sel) == trig_sel && fill_count >= lvl)
        |-> rts_n);

    // R5
    rts_reassert_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(auto_rts_en) && $past(trig_sel) == trig_sel && fill_count <= rel)
        |-> !rts_n);

    // R6
    rts_manual_chk: assert property (@(posedge clk) disable iff (rst)
        !auto_rts_en |=> rts_n);

    // R9
    timeout_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en || rd_en) |=> !timeout_irq);

    // R10
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |=> (fill_count == '0));

endmodule

bind rx_fifo_rts rx_fifo_rts_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .fifo_en     (fifo_en),
    .trig_sel    (trig_sel),
    .auto_rts_en (auto_rts_en),
    .fill_count  (fill_count),
    .timeout_irq (timeout_irq),
    .overrun     (overrun),
    .rts_n       (rts_n)
);

// File: tb/rx_fifo_rts_test.sv
module rx_fifo_rts_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic       fifo_en = 1'b1;
    logic [1:0] trig_sel = 2'b00;
    logic       auto_rts_en = 1'b0;
    logic       char_tick = 1'b0;
    logic [7:0] rd_data;
    logic [5:0] fill_count;
    logic       data_ready, trig_irq, timeout_irq, overrun, rts_n;

    always #10 clk = ~clk;

    rx_fifo_rts uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .fifo_en(fifo_en), .trig_sel(trig_sel), .auto_rts_en(auto_rts_en),
        .char_tick(char_tick), .rd_data(rd_data), .fill_count(fill_count),
        .data_ready(data_ready), .trig_irq(trig_irq), .timeout_irq(timeout_irq),
        .overrun(overrun), .rts_n(rts_n)
    );

    int checks = 0;
    int fails  = 0;
    logic [7:0] mq[$];
    logic m_rts = 1'b1;
    logic m_ovr = 1'b0;
    int   m_to  = 0;
    logic [7:0] seq = 8'h00;
    bit done = 1'b0;

    function automatic int lvl(logic [1:0] s);
        case (s) 2'd0: return 8; 2'd1: return 16; 2'd2: return 24; default: return 28; endcase
    endfunction

    function automatic int rel(logic [1:0] s);
        case (s) 2'd0: return 0; 2'd1: return 7; 2'd2: return 15; default: return 23; endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        int n;
        n = mq.size();
        check("R2 fill_count", fill_count, n);
        check("R2 data_ready", data_ready, n != 0);
        if (n > 0) check("R2 rd_data", rd_data, mq[0]);
        check("R3 trig_irq", trig_irq, n >= lvl(trig_sel));
        check("R5 rts_n", rts_n, m_rts);
        check("R8 overrun", overrun, m_ovr);
        check("R9 timeout_irq", timeout_irq, (m_to == 4) && n > 0 && n < lvl(trig_sel));
    endtask

    task automatic model_update();
        int cnt;
        bit pop, push, oset;
        cnt = mq.size();
        if (wr_en || rd_en || !(cnt > 0 && cnt < lvl(trig_sel))) m_to = 0;
        else if (char_tick && m_to < 4) m_to++;
        pop  = fifo_en && rd_en && cnt > 0;
        push = fifo_en && wr_en && (cnt < 32 || pop);
        oset = fifo_en && wr_en && cnt == 32 && !pop;
        if (!fifo_en) mq.delete();
        if (pop) void'(mq.pop_front());
        if (push) mq.push_back(wr_data);
        if (oset) m_ovr = 1'b1;
        else if (rd_en) m_ovr = 1'b0;
        if (!auto_rts_en) m_rts = 1'b1;
        else if (mq.size() >= lvl(trig_sel)) m_rts = 1'b1;
        else if (mq.size() <= rel(trig_sel)) m_rts = 1'b0;
    endtask

    task automatic step(bit w, bit r, bit t);
        wr_en = w; rd_en = r; char_tick = t;
        if (w) begin wr_data = seq; seq = seq + 8'd37; end
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
        wr_en = 1'b0; rd_en = 1'b0; char_tick = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_up();
    end

    initial begin
        void'($urandom(32'd4321));
        // R1: reset state
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 fill_count", fill_count, 0);
        check("R1 rts_n", rts_n, 1);
        check("R1 overrun", overrun, 0);
        check("R1 irqs", {trig_irq, timeout_irq, data_ready}, 0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 rts_n after release", rts_n, 1);
        compare_all();

        // R4 / R5: level 8, release at 0
        auto_rts_en = 1'b1; trig_sel = 2'b00;
        step(0, 0, 0);
        check("R5 rts_n empty", rts_n, 0);
        for (int i = 0; i < 7; i++) step(1, 0, 0);
        check("R4 rts_n below level", rts_n, 0);
        step(1, 0, 0);
        check("R4 rts_n at level", rts_n, 1);
        check("R3 trig_irq at 8", trig_irq, 1);
        for (int i = 0; i < 7; i++) step(0, 1, 0);
        check("R5 rts_n hold at 1", rts_n, 1);
        step(0, 1, 0);
        check("R5 rts_n released at 0", rts_n, 0);

        // R9: timeout
        step(1, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 1);
        check("R9 timeout before 4", timeout_irq, 0);
        step(0, 0, 1);
        check("R9 timeout after 4", timeout_irq, 1);
        step(0, 0, 0);
        check("R9 timeout held", timeout_irq, 1);
        step(1, 0, 1);
        check("R9 timeout cleared", timeout_irq, 0);
        step(0, 1, 0); step(0, 1, 0);

        // R7 / R8: level 28, fill to full, then overrun
        trig_sel = 2'b11;
        step(0, 0, 0);
        for (int i = 0; i < 28; i++) step(1, 0, 0);
        check("R4 rts_n at 28", rts_n, 1);
        for (int i = 0; i < 4; i++) step(1, 0, 0);
        check("R7 count full", fill_count, 32);
        step(1, 0, 0);
        check("R8 overrun set", overrun, 1);
        check("R8 count unchanged", fill_count, 32);
        step(0, 0, 0);
        check("R8 overrun sticky", overrun, 1);
        step(1, 1, 0);
        check("R8 read+write count", fill_count, 32);
        check("R8 overrun cleared", overrun, 0);
        for (int i = 0; i < 9; i++) step(0, 1, 0);
        check("R5 rts_n at 23", rts_n, 0);

        // R6: auto off
        auto_rts_en = 1'b0;
        step(0, 0, 0);
        check("R6 rts_n manual", rts_n, 1);
        auto_rts_en = 1'b1;

        // R10: disable flushes and drops writes
        fifo_en = 1'b0;
        step(1, 0, 0);
        check("R10 flushed", fill_count, 0);
        step(1, 0, 0);
        check("R10 write dropped", fill_count, 0);
        check("R10 no overrun", overrun, 0);
        fifo_en = 1'b1;
        step(0, 1, 0);
        check("R2 read empty ignored", fill_count, 0);

        // Random phases
        for (int ph = 0; ph < 40; ph++) begin
            int wp, rp;
            wp = (ph % 2 == 0) ? 80 : 30;
            rp = (ph % 2 == 0) ? 25 : 75;
            trig_sel = 2'($urandom % 4);
            auto_rts_en = ($urandom % 8) != 0;
            for (int k = 0; k < 100; k++) begin
                fifo_en = ($urandom % 300) != 0;
                step(($urandom % 100) < wp, ($urandom % 100) < rp, ($urandom % 3) == 0);
            end
            fifo_en = 1'b1;
            if (ph % 5 == 4) for (int k = 0; k < 12; k++) step(0, 0, 1);
        end

        finish_up();
    end

endmodule